// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block watches the command bus of a four-bank SDRAM on every rising clock edge and tells the rest of the controller which command was accepted, which bank it aims at, and whether it is legal in the current bank state. It decodes the active-low chip select together with the row, column and write strobes, the present and previous clock-enable levels and address bit 10. Address bit 10 selects auto-precharge on reads and writes, and precharge-all on precharges.

For each bank it keeps an idle or open state. It models the automatic close that follows a read or write with auto-precharge, using a fixed burst length in clock cycles. It also follows the low-power states that clock enable controls: power-down, self-refresh, and clock suspend while a row is open. A protocol monitor or a memory model can use the decoded indication and the illegal flag to catch controller mistakes one cycle at a time.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: With chip select high and a command accepted, only the no-op bit (bit 0) of `cmdOneHot` is set, `illegal` stays low and no bank changes state.
- R2: An accepted command sets one bit of `cmdOneHot` in the same cycle, from the strobe levels {row, column, write}: 111 bit 0 no-op, 011 bit 1 activate, 101 bit 2 read, 100 bit 3 write, 010 bit 4 precharge, 001 bit 5 refresh, 110 bit 6 burst stop, 000 bit 7 mode set. `cmdBank` equals `bankAddr`.
- R3: An activate to an idle bank opens it from the next cycle. An activate to an open bank raises `illegal` and changes nothing.
- R4: A read or write to an idle bank raises `illegal` and changes no bank state.
- R5: A legal read or write with `a10` high raises `autoPre`. That bank then reads idle exactly BURST_LEN run-mode edges after the command edge. While the bank is closing, a read, write or activate to it is illegal.
- R6: A precharge closes the addressed bank from the next cycle. With `a10` high it raises `preAll` and closes every bank.
- R7: Refresh and mode set are illegal while any bank is open. With all banks idle they are legal and leave all banks idle.
- R8: Pattern 001 with previous clock enable high and current low sets bit 8 instead of bit 5. With all banks idle it enters self-refresh, which holds while clock enable stays low and ends at the first edge where it is high.
- R9: A no-op or deselect with clock enable falling and all banks idle enters power-down. Any other command in that situation is illegal and leaves the mode unchanged.
- R10: Clock enable falling with a bank open lets that cycle's command take effect, then suspends from the next cycle. In suspend the auto-precharge countdown is frozen.
- R11: After reset all banks are idle, no low-power state is set and no command is indicated when chip select is high with previous clock enable low.
- R12: In any low-power state, or when previous clock enable is low, commands are ignored: `cmdOneHot` is zero and `illegal` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write strobe, active low |
| ckePrev | input | 1 | Clock enable sampled in the previous cycle |
| ckeCur | input | 1 | Clock enable in this cycle |
| bankAddr | input | 2 | Target bank |
| a10 | input | 1 | Auto-precharge / precharge-all option bit |
| cmdOneHot | output | 9 | Accepted command, one-hot (see R2, R8) |
| cmdBank | output | 2 | Bank the command addresses |
| autoPre | output | 1 | Read or write with auto-precharge |
| preAll | output | 1 | Precharge of every bank |
| illegal | output | 1 | Command illegal in the current state |
| bankActive | output | 4 | Per-bank open flag |
| inPowerDown | output | 1 | Power-down state |
| inSelfRefresh | output | 1 | Self-refresh state |
| inSuspend | output | 1 | Clock suspend state |

## Verification
The hardest situation to reach is an auto-precharge countdown frozen part-way by clock suspend. It needs an open bank, then a read with `a10` high issued in the same cycle that clock enable falls, then several suspended cycles and a resume. A directed sequence builds exactly that and checks that the bank stays open through the suspend and closes BURST_LEN run edges after the command. Random traffic then mixes bursts of low clock enable with random strobes, so that power-down, self-refresh and suspend are each entered from both idle and open bank states.

// File: rtl/sdram_trk_pkg.sv
package sdram_trk_pkg;
  localparam int BANK_ADDR_W = 2;
  localparam int NUM_BANKS   = 1 << BANK_ADDR_W;
  localparam int CMD_W       = 9;

  localparam int CMD_NOP   = 0;
  localparam int CMD_ACT   = 1;
  localparam int CMD_READ  = 2;
  localparam int CMD_WRITE = 3;
  localparam int CMD_PRE   = 4;
  localparam int CMD_REFA  = 5;
  localparam int CMD_TERM  = 6;
  localparam int CMD_MRS   = 7;
  localparam int CMD_SREF  = 8;

  typedef enum logic [1:0] {MODE_RUN, MODE_PDN, MODE_SREF, MODE_SUSP} mode_e;

  typedef struct packed {
    logic                   actEn;
    logic                   closeEn;
    logic                   closeAll;
    logic                   armClose;
    logic [BANK_ADDR_W-1:0] bank;
  } bankStrobe_t;
endpackage

// File: rtl/sdram_cmd_ctrl.sv
module sdram_cmd_ctrl
  import sdram_trk_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   csN,
  input  logic                   rasN,
  input  logic                   casN,
  input  logic                   weN,
  input  logic                   ckePrev,
  input  logic                   ckeCur,
  input  logic [BANK_ADDR_W-1:0] bankAddr,
  input  logic                   a10,
  input  logic [NUM_BANKS-1:0]   bankOpen,
  input  logic [NUM_BANKS-1:0]   bankClosing,
  output logic [CMD_W-1:0]       cmdOneHot,
  output logic                   illegal,
  output logic                   autoPre,
  output logic                   preAll,
  output bankStrobe_t            stb,
  output mode_e                  mode
);
  mode_e modeNext;
  int    rawIdx;
  logic  anyOpen;

  assign anyOpen = |bankOpen;

  always_comb begin
    case ({rasN, casN, weN})
      3'b111:  rawIdx = CMD_NOP;
      3'b011:  rawIdx = CMD_ACT;
      3'b101:  rawIdx = CMD_READ;
      3'b100:  rawIdx = CMD_WRITE;
      3'b010:  rawIdx = CMD_PRE;
      3'b001:  rawIdx = CMD_REFA;
      3'b110:  rawIdx = CMD_TERM;
      default: rawIdx = CMD_MRS;
    endcase
  end

  always_comb begin
    cmdOneHot = '0;
    illegal   = 1'b0;
    stb       = '0;
    stb.bank  = bankAddr;
    modeNext  = mode;
    if (mode == MODE_RUN) begin
      if (ckePrev) begin
        if (csN)                                  cmdOneHot[CMD_NOP]  = 1'b1;
        else if (rawIdx == CMD_REFA && !ckeCur)   cmdOneHot[CMD_SREF] = 1'b1;
        else                                      cmdOneHot[rawIdx]   = 1'b1;

        if (!ckeCur && !anyOpen) begin
          if (csN || rawIdx == CMD_NOP)  modeNext = MODE_PDN;
          else if (rawIdx == CMD_REFA)   modeNext = MODE_SREF;
          else                           illegal  = 1'b1;
        end else begin
          if (!csN) begin
            case (rawIdx)
              CMD_ACT: begin
                if (bankOpen[bankAddr]) illegal   = 1'b1;
                else                    stb.actEn = 1'b1;
              end
              CMD_READ, CMD_WRITE: begin
                if (!bankOpen[bankAddr] || bankClosing[bankAddr]) illegal = 1'b1;
                else if (a10)                                       stb.armClose = 1'b1;
              end
              CMD_PRE: begin
                if (a10) stb.closeAll = 1'b1;
                else     stb.closeEn  = 1'b1;
              end
              CMD_REFA, CMD_MRS: begin
                if (anyOpen) illegal = 1'b1;
              end
              default: ;
            endcase
          end
          if (!ckeCur) modeNext = MODE_SUSP;
        end
      end
    end else if (ckeCur) begin
      modeNext = MODE_RUN;
    end
  end

  assign autoPre = (cmdOneHot[CMD_READ] | cmdOneHot[CMD_WRITE]) & a10 & ~illegal;
  assign preAll  = cmdOneHot[CMD_PRE] & a10;

  always_ff @(posedge clk) begin
    if (!rst_n) mode <= MODE_RUN;
    else        mode <= modeNext;
  end
endmodule

// File: rtl/sdram_bank_dp.sv
module sdram_bank_dp
  import sdram_trk_pkg::*;
#(
  parameter int BURST_LEN = 4,
  localparam int CNT_W = $clog2(BURST_LEN + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  bankStrobe_t          stb,
  input  logic                 freeze,
  output logic [NUM_BANKS-1:0] bankOpen,
  output logic [NUM_BANKS-1:0] bankClosing
);
  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    logic [CNT_W-1:0] closeCnt;
    logic             hit;

    assign hit            = (stb.bank == BANK_ADDR_W'(i));
    assign bankClosing[i] = (closeCnt != '0);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bankOpen[i] <= 1'b0;
        closeCnt    <= '0;
      end else if (stb.closeAll || (stb.closeEn && hit)) begin
        bankOpen[i] <= 1'b0;
        closeCnt    <= '0;
      end else if (stb.actEn && hit) begin
        bankOpen[i] <= 1'b1;
      end else if (stb.armClose && hit) begin
        closeCnt <= CNT_W'(BURST_LEN);
      end else if (!freeze && closeCnt != '0) begin
        closeCnt <= closeCnt - CNT_W'(1);
        if (closeCnt == CNT_W'(1)) bankOpen[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
  import sdram_trk_pkg::*;
#(
  parameter int BURST_LEN = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   csN,
  input  logic                   rasN,
  input  logic                   casN,
  input  logic                   weN,
  input  logic                   ckePrev,
  input  logic                   ckeCur,
  input  logic [BANK_ADDR_W-1:0] bankAddr,
  input  logic                   a10,
  output logic [CMD_W-1:0]       cmdOneHot,
  output logic [BANK_ADDR_W-1:0] cmdBank,
  output logic                   autoPre,
  output logic                   preAll,
  output logic                   illegal,
  output logic [NUM_BANKS-1:0]   bankActive,
  output logic                   inPowerDown,
  output logic                   inSelfRefresh,
  output logic                   inSuspend
);
  bankStrobe_t          stb;
  mode_e                mode;
  logic [NUM_BANKS-1:0] bankClosing;

  sdram_cmd_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .ckePrev(ckePrev), .ckeCur(ckeCur), .bankAddr(bankAddr), .a10(a10),
    .bankOpen(bankActive), .bankClosing(bankClosing),
    .cmdOneHot(cmdOneHot), .illegal(illegal), .autoPre(autoPre), .preAll(preAll),
    .stb(stb), .mode(mode)
  );

  sdram_bank_dp #(.BURST_LEN(BURST_LEN)) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .freeze(mode == MODE_SUSP),
    .bankOpen(bankActive), .bankClosing(bankClosing)
  );

  assign cmdBank       = bankAddr;
  assign inPowerDown   = (mode == MODE_PDN);
  assign inSelfRefresh = (mode == MODE_SREF);
  assign inSuspend     = (mode == MODE_SUSP);
endmodule

// File: rtl/sdram_cmd_tracker_chk.sv
module sdram_cmd_tracker_chk
  import sdram_trk_pkg::*;
(
  input logic                   clk,
  input logic                   rst_n,
  input logic                   csN,
  input logic                   ckeCur,
  input logic [CMD_W-1:0]       cmdOneHot,
  input logic [BANK_ADDR_W-1:0] cmdBank,
  input logic                   preAll,
  input logic                   illegal,
  input logic [NUM_BANKS-1:0]   bankActive,
  input logic                   inPowerDown,
  input logic                   inSelfRefresh,
  input logic                   inSuspend
);
  logic [NUM_BANKS-1:0] actMask;
  assign actMask = (cmdOneHot[CMD_ACT] && !illegal) ? NUM_BANKS'(1) << cmdBank : '0;

  // R1
  deselect_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csN |-> ((cmdOneHot & ~CMD_W'(1)) == '0) && !illegal);

  // R2
  onehot_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmdOneHot));

  // R3
  act_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (actMask != '0) |=> ((bankActive & $past(actMask)) == $past(actMask)));

  // R4
  rw_idle_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmdOneHot[CMD_READ] || cmdOneHot[CMD_WRITE]) && !bankActive[cmdBank]) |-> illegal);

  // R6
  pre_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    preAll |=> (bankActive == '0));

  // R7
  refresh_open_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdOneHot[CMD_REFA] && (bankActive != '0)) |-> illegal);

  // R8
  sref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inSelfRefresh && !ckeCur) |=> inSelfRefresh);

  // R9
  pdn_idle_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(inPowerDown) |-> ($past(bankActive) == '0));

  // R12
  lowpower_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inPowerDown || inSelfRefresh || inSuspend) |-> (cmdOneHot == '0) && !illegal);

  // R10
  one_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({inPowerDown, inSelfRefresh, inSuspend}));
endmodule

bind sdram_cmd_tracker sdram_cmd_tracker_chk u_chk (.*);

// File: tb/tb_sdram_cmd_tracker.sv
`timescale 1ns/1ps
module tb_sdram_cmd_tracker;
  localparam int BL = 4;
  localparam time CLK_P = 20ns;

  logic clk = 0, rst_n = 0;
  logic csN = 1, rasN = 1, casN = 1, weN = 1, ckePrev = 1, ckeCur = 1, a10 = 0;
  logic [1:0] bankAddr = 0;
  logic [8:0] cmdOneHot;
  logic [1:0] cmdBank;
  logic autoPre, preAll, illegal, inPowerDown, inSelfRefresh, inSuspend;
  logic [3:0] bankActive;

  int checks = 0, errors = 0;
  bit finished = 0;

  bit mOpen[4];
  int mCnt[4];
  int mMode;       // 0 run, 1 power-down, 2 self-refresh, 3 suspend
  bit lastCke;

  always #(CLK_P/2) clk = ~clk;

  sdram_cmd_tracker #(.BURST_LEN(BL)) dut (.*);

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int strobeIdx(input logic [2:0] s);
    case (s)
      3'b111: return 0; 3'b011: return 1; 3'b101: return 2; 3'b100: return 3;
      3'b010: return 4; 3'b001: return 5; 3'b110: return 6; default: return 7;
    endcase
  endfunction

  task automatic checkState(input string tag);
    logic [3:0] eAct;
    for (int b = 0; b < 4; b++) eAct[b] = mOpen[b];
    check(tag, "bankActive", bankActive, eAct);
    check(tag, "inPowerDown", inPowerDown, mMode == 1);
    check(tag, "inSelfRefresh", inSelfRefresh, mMode == 2);
    check(tag, "inSuspend", inSuspend, mMode == 3);
  endtask

  // called at a falling edge
  task automatic step(input logic cs, input logic [2:0] strobes, input logic cke,
                      input logic [1:0] ba, input logic ap, input string tag);
    logic [8:0] eHot;
    bit eIll, doAct, doClose, doAll, doArm, anyOpen;
    int idx, nm;
    csN = cs; {rasN, casN, weN} = strobes; ckeCur = cke; ckePrev = lastCke;
    bankAddr = ba; a10 = ap;
    #2;
    eHot = 0; eIll = 0; doAct = 0; doClose = 0; doAll = 0; doArm = 0; nm = mMode;
    idx = strobeIdx(strobes);
    anyOpen = mOpen[0] | mOpen[1] | mOpen[2] | mOpen[3];
    if (mMode == 0 && lastCke) begin
      if (cs) eHot[0] = 1;
      else if (idx == 5 && !cke) eHot[8] = 1;
      else eHot[idx] = 1;
      if (!cke && !anyOpen) begin
        if (cs || idx == 0) nm = 1;
        else if (idx == 5) nm = 2;
        else eIll = 1;
      end else begin
        if (!cs) begin
          case (idx)
            1: if (mOpen[ba]) eIll = 1; else doAct = 1;
            2, 3: if (!mOpen[ba] || mCnt[ba] != 0) eIll = 1; else if (ap) doArm = 1;
            4: if (ap) doAll = 1; else doClose = 1;
            5, 7: if (anyOpen) eIll = 1;
            default: ;
          endcase
        end
        if (!cke) nm = 3;
      end
    end else if (mMode != 0 && cke) nm = 0;
    check(tag, "cmdOneHot", cmdOneHot, eHot);
    check(tag, "illegal", illegal, eIll);
    check(tag, "cmdBank", cmdBank, ba);
    check(tag, "autoPre", autoPre, (eHot[2] | eHot[3]) & ap & !eIll);
    check(tag, "preAll", preAll, eHot[4] & ap);
    @(posedge clk);
    for (int b = 0; b < 4; b++) begin
      if (doAll || (doClose && ba == b)) begin mOpen[b] = 0; mCnt[b] = 0; end
      else if (doAct && ba == b) mOpen[b] = 1;
      else if (doArm && ba == b) mCnt[b] = BL;
      else if (mMode != 3 && mCnt[b] > 0) begin
        mCnt[b]--;
        if (mCnt[b] == 0) mOpen[b] = 0;
      end
    end
    mMode = nm; lastCke = cke;
    @(negedge clk);
    checkState(tag);
  endtask

  localparam logic [2:0] S_NOP = 3'b111, S_ACT = 3'b011, S_RD = 3'b101, S_WR = 3'b100,
                         S_PRE = 3'b010, S_REF = 3'b001, S_MRS = 3'b000;

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5D3A_0001));
    for (int b = 0; b < 4; b++) begin mOpen[b] = 0; mCnt[b] = 0; end
    mMode = 0; lastCke = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    checkState("R11");
    ckePrev = 0; csN = 1; #1;
    check("R11", "cmdOneHot idle", cmdOneHot, 0);

    step(1, S_ACT, 1, 1, 0, "R1");         // deselect with activate strobes
    step(0, S_ACT, 1, 1, 0, "R3");
    step(0, S_ACT, 1, 1, 0, "R3");         // second activate: illegal
    step(0, S_RD, 1, 2, 0, "R4");
    step(0, S_WR, 1, 0, 1, "R4");
    step(0, S_WR, 1, 1, 0, "R2");
    step(0, S_RD, 1, 1, 1, "R5");          // arm auto-precharge
    step(0, S_RD, 1, 1, 0, "R5");          // closing bank: illegal
    step(0, S_ACT, 1, 1, 0, "R5");
    for (int i = 0; i < 3; i++) step(0, S_NOP, 1, 0, 0, "R5");
    check("R5", "bank1 closed", bankActive[1], 0);
    step(0, S_ACT, 1, 0, 0, "R6");
    step(0, S_ACT, 1, 3, 0, "R6");
    step(0, S_PRE, 1, 0, 0, "R6");
    step(0, S_ACT, 1, 2, 0, "R6");
    step(0, S_PRE, 1, 1, 1, "R6");
    step(0, S_ACT, 1, 2, 0, "R7");
    step(0, S_REF, 1, 0, 0, "R7");
    step(0, S_MRS, 1, 0, 0, "R7");
    step(0, S_PRE, 1, 0, 1, "R7");
    step(0, S_REF, 1, 0, 0, "R7");
    step(0, S_MRS, 1, 0, 0, "R7");
    step(0, S_REF, 0, 0, 0, "R8");         // self-refresh entry
    for (int i = 0; i < 3; i++) step(0, S_ACT, 0, 1, 0, "R8");
    step(0, S_ACT, 1, 1, 0, "R8");         // exit
    step(0, S_ACT, 0, 2, 0, "R9");         // illegal falling, idle
    step(0, S_ACT, 0, 2, 0, "R12");        // previous enable low: ignored
    step(0, S_ACT, 1, 2, 0, "R12");
    step(0, S_NOP, 0, 0, 0, "R9");         // power-down entry
    step(0, S_ACT, 0, 0, 0, "R12");
    step(1, S_NOP, 1, 0, 0, "R9");
    step(0, S_NOP, 1, 0, 0, "R9");
    step(0, S_ACT, 1, 1, 0, "R10");
    step(0, S_RD, 0, 1, 1, "R10");         // arm while suspending
    for (int i = 0; i < 5; i++) step(0, S_PRE, 0, 1, 1, "R10");
    check("R10", "bank1 held open", bankActive[1], 1);
    step(0, S_NOP, 1, 0, 0, "R10");
    for (int i = 0; i < 5; i++) step(0, S_NOP, 1, 0, 0, "R10");

    for (int i = 0; i < 4000; i++) begin
      logic cs, cke;
      cs  = ($urandom_range(99) < 12);
      cke = lastCke ? ($urandom_range(99) >= 4) : ($urandom_range(99) < 35);
      step(cs, 3'($urandom_range(7)), cke, 2'($urandom_range(3)),
           ($urandom_range(99) < 30), "R2");
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule